// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block models the command logic inside a small byte-wide parallel flash, with the array placed on chip. A host drives an asynchronous-style bus: chip enable, write enable, output enable, an address and a data byte, all active-low strobes sampled on a system clock. Write cycles are taken on the rising edge of the write strobe while the chip is enabled. The decoder matches these writes against multi-cycle unlock sequences and, when a full sequence arrives, starts an embedded algorithm.

Three algorithms are supported. Program stores one byte, and it can only clear bits. Sector erase and chip erase each first force every byte in their range to 00h and then set the whole range to FFh. Each algorithm takes a parameterised number of clock cycles. While an algorithm runs, the busy pin is high and bus reads return a polling status byte in place of array data. An overrun limit, or a test input, aborts the operation and raises the timeout bit in that status byte.

The strobes, busy and the test input are plain control and status pins with no handshake. The host holds each strobe level for at least one clock cycle, so the block never applies back-pressure. A host that writes while busy is high simply has its writes dropped.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, busy is 0 and dout is 00h.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then D@PA program address PA. After busy falls, PA reads (old AND D). The command address is matched on addr[10:0].
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address in a sector erase that sector only. A sector is addr[10:9], 512 bytes. Every byte in the sector then reads FFh, and bytes outside it keep their values.
- R4: The same five leading writes followed by 10h@555h erase the whole array, so every byte then reads FFh.
- R5: Before setting its range to FFh, an erase writes 00h to every byte of that range. The erase then waits ERASE_CYC cycles before the FFh pass.
- R6: While busy is high, a read returns the status byte. Bit 7 is the complement of the target bit 7, which is the data's bit 7 for a program and 1 for an erase. Bit 5 is the timeout flag. All other bits are 0.
- R7: Busy rises once a command is accepted and falls when the algorithm ends. Reads then return array data.
- R8: A write that does not match the next expected address/data of a sequence returns the decoder to the read state. Later writes must restart from AAh@555h.
- R9: If an operation reaches TMO_CYC cycles, or force_tmo is high while it runs, the operation stops and no further array write occurs. Busy stays high with status bit 5 set until a write of F0h clears it.
- R10: Writes arriving while busy is high start no new command, except F0h in the timeout state.
- R11: dout is registered. It reflects the read one clock after ce_n and oe_n are both low, and it is 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |
| busy | output | 1 | High while an embedded algorithm runs or is in timeout |
| force_tmo | input | 1 | Test input that forces a timeout on the running operation |

## Verification
The erase's 00h pre-program pass is the hardest thing to see from the ports. Every read during an erase returns status, and a completed erase overwrites the range with FFh. The bench starts a sector erase and waits past the pre-program pass into the erase wait window. It then pulses force_tmo, which freezes the array in its intermediate state. After the F0h recovery write, it reads bytes that previously held nonzero data and expects 00h. That same run also exercises the timeout status bit and the recovery path.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    D_READ, D_UNL1, D_UNL2, D_PARM, D_ERS3, D_ERS4, D_ERS5
  } dec_st_t;

  typedef enum logic [2:0] {
    A_IDLE, A_PROG, A_PRE, A_WAIT, A_ERASE, A_FAIL
  } alg_st_t;

  localparam logic [10:0] CMD_ADDR_A = 11'h555;
  localparam logic [10:0] CMD_ADDR_B = 11'h2AA;
  localparam logic [7:0]  K_UNL1  = 8'hAA;
  localparam logic [7:0]  K_UNL2  = 8'h55;
  localparam logic [7:0]  K_PROG  = 8'hA0;
  localparam logic [7:0]  K_ERS   = 8'h80;
  localparam logic [7:0]  K_SECT  = 8'h30;
  localparam logic [7:0]  K_CHIP  = 8'h10;
  localparam logic [7:0]  K_RESET = 8'hF0;
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              busy,
  input  logic              alg_fail,
  output logic              prog_go,
  output logic              erase_go,
  output logic              erase_chip,
  output logic [ADDR_W-1:0] go_addr,
  output logic [7:0]        go_data,
  output logic              clr_fail
);
  dec_st_t st;
  logic we_q, wr_evt, accept, at_a, at_b;

  assign wr_evt = !ce_n && we_n && !we_q;
  assign accept = wr_evt && !busy && !prog_go && !erase_go;
  assign at_a   = (addr[10:0] == CMD_ADDR_A);
  assign at_b   = (addr[10:0] == CMD_ADDR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= D_READ;
      we_q       <= 1'b1;
      prog_go    <= 1'b0;
      erase_go   <= 1'b0;
      erase_chip <= 1'b0;
      go_addr    <= '0;
      go_data    <= '0;
      clr_fail   <= 1'b0;
    end else begin
      we_q     <= we_n;
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
      clr_fail <= wr_evt && alg_fail && (din == K_RESET);
      if (accept) begin
        st <= D_READ;
        case (st)
          D_READ: if (at_a && din == K_UNL1) st <= D_UNL1;
          D_UNL1: if (at_b && din == K_UNL2) st <= D_UNL2;
          D_UNL2: begin
            if (at_a && din == K_PROG) st <= D_PARM;
            else if (at_a && din == K_ERS) st <= D_ERS3;
          end
          D_PARM: begin
            prog_go <= 1'b1;
            go_addr <= addr;
            go_data <= din;
          end
          D_ERS3: if (at_a && din == K_UNL1) st <= D_ERS4;
          D_ERS4: if (at_b && din == K_UNL2) st <= D_ERS5;
          D_ERS5: begin
            if (din == K_SECT) begin
              erase_go   <= 1'b1;
              erase_chip <= 1'b0;
              go_addr    <= addr;
            end else if (at_a && din == K_CHIP) begin
              erase_go   <= 1'b1;
              erase_chip <= 1'b1;
              go_addr    <= addr;
            end
          end
          default: st <= D_READ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_embedded_alg.sv
module flash_embedded_alg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 256,
  parameter int TMO_CYC   = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic              erase_chip,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [7:0]        go_data,
  input  logic              clr_fail,
  input  logic              force_tmo,
  input  logic [7:0]        mem_old,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              fail,
  output logic              pol7,
  output logic              erase_ph
);
  localparam int OFS_W = ADDR_W - SECT_W;
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int TW    = $clog2(TMO_CYC + 1);

  alg_st_t st;
  logic [ADDR_W-1:0] tgt, ptr, lo, hi, lo_n, hi_n;
  logic [7:0]        pdata;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     timer;
  logic              active, expire;

  assign active = (st == A_PROG) || (st == A_PRE) || (st == A_WAIT) || (st == A_ERASE);
  assign expire = active && (force_tmo || timer == TW'(TMO_CYC - 1));

  always_comb begin
    if (erase_chip) begin
      lo_n = '0;
      hi_n = '1;
    end else begin
      lo_n = {go_addr[ADDR_W-1 -: SECT_W], {OFS_W{1'b0}}};
      hi_n = {go_addr[ADDR_W-1 -: SECT_W], {OFS_W{1'b1}}};
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = 8'h00;
    case (st)
      A_PROG: begin
        mem_addr = tgt;
        if (cnt == CW'(PROG_CYC - 1)) begin
          mem_we    = 1'b1;
          mem_wdata = mem_old & pdata;
        end
      end
      A_PRE:   mem_we = 1'b1;
      A_ERASE: begin
        mem_we    = 1'b1;
        mem_wdata = 8'hFF;
      end
      default: ;
    endcase
    if (expire) mem_we = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= A_IDLE;
      tgt   <= '0;
      ptr   <= '0;
      lo    <= '0;
      hi    <= '0;
      pdata <= '0;
      cnt   <= '0;
      timer <= '0;
      pol7  <= 1'b0;
    end else begin
      if (active) timer <= timer + 1'b1;
      if (expire) st <= A_FAIL;
      else begin
        case (st)
          A_IDLE: begin
            if (prog_go) begin
              st    <= A_PROG;
              tgt   <= go_addr;
              pdata <= go_data;
              pol7  <= go_data[7];
              cnt   <= '0;
              timer <= '0;
            end else if (erase_go) begin
              st    <= A_PRE;
              lo    <= lo_n;
              hi    <= hi_n;
              ptr   <= lo_n;
              pol7  <= 1'b1;
              timer <= '0;
            end
          end
          A_PROG: begin
            if (cnt == CW'(PROG_CYC - 1)) st <= A_IDLE;
            else cnt <= cnt + 1'b1;
          end
          A_PRE: begin
            if (ptr == hi) begin
              st  <= A_WAIT;
              ptr <= lo;
              cnt <= '0;
            end else ptr <= ptr + 1'b1;
          end
          A_WAIT: begin
            if (cnt == CW'(ERASE_CYC - 1)) st <= A_ERASE;
            else cnt <= cnt + 1'b1;
          end
          A_ERASE: begin
            if (ptr == hi) st <= A_IDLE;
            else ptr <= ptr + 1'b1;
          end
          A_FAIL: if (clr_fail) st <= A_IDLE;
          default: st <= A_IDLE;
        endcase
      end
    end
  end

  assign busy     = (st != A_IDLE);
  assign fail     = (st == A_FAIL);
  assign erase_ph = (st == A_ERASE);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr_bus,
  output logic [7:0]        rdata_bus,
  output logic [7:0]        rdata_alg
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_bus = mem[raddr_bus];
  assign rdata_alg = mem[waddr];
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 256,
  parameter int TMO_CYC   = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy,
  input  logic              force_tmo
);
  logic              prog_go, erase_go, erase_chip, clr_fail, go_any;
  logic [ADDR_W-1:0] go_addr, mem_addr;
  logic [7:0]        go_data, mem_wdata, mem_old, rd_data, status;
  logic              mem_we, fail, pol7, erase_ph;

  assign go_any = prog_go || erase_go;

  flash_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .busy(busy), .alg_fail(fail), .prog_go(prog_go), .erase_go(erase_go),
    .erase_chip(erase_chip), .go_addr(go_addr), .go_data(go_data), .clr_fail(clr_fail)
  );

  flash_embedded_alg #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .TMO_CYC(TMO_CYC)
  ) u_alg (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .erase_chip(erase_chip), .go_addr(go_addr), .go_data(go_data),
    .clr_fail(clr_fail), .force_tmo(force_tmo), .mem_old(mem_old),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .fail(fail), .pol7(pol7), .erase_ph(erase_ph)
  );

  flash_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr_bus(addr), .rdata_bus(rd_data), .rdata_alg(mem_old)
  );

  assign status = {~pol7, 1'b0, fail, 5'b00000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 8'h00;
    else if (!ce_n && !oe_n) dout <= busy ? status : rd_data;
    else dout <= 8'h00;
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int ADDR_W = 11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       busy,
  input logic       force_tmo,
  input logic [7:0] dout,
  input logic       mem_we,
  input logic       erase_ph,
  input logic [7:0] mem_wdata,
  input logic [7:0] mem_old,
  input logic       fail,
  input logic       go_any
);
  // R6
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && busy) |=> (dout[6] == 1'b0 && dout[4:0] == 5'b0));
  // R10
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R9
  force_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fail && force_tmo) |=> fail);
  // R9
  fail_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !mem_we);
  // R7
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |-> !busy);
  // R2
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !erase_ph) |-> ((mem_wdata & ~mem_old) == 8'h00));
  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> (dout == 8'h00));
endmodule

bind flash_cmd_engine flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
  .force_tmo(force_tmo), .dout(dout), .mem_we(mem_we), .erase_ph(erase_ph),
  .mem_wdata(mem_wdata), .mem_old(mem_old), .fail(fail), .go_any(go_any)
);

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, force_tmo = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic busy;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_engine i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .force_tmo(force_tmo)
  );

  // {address, program data, expected byte, expected status while busy}
  localparam logic [34:0] VEC [6] = '{
    {11'h010, 8'h5A, 8'h5A, 8'h80},
    {11'h010, 8'hF0, 8'h50, 8'h00},
    {11'h200, 8'h00, 8'h00, 8'h80},
    {11'h7FF, 8'h81, 8'h81, 8'h00},
    {11'h3C0, 8'h7F, 8'h7F, 8'h80},
    {11'h010, 8'h0F, 8'h00, 8'h80}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    @(negedge clk); d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic cmd_prog(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic cmd_erase(input logic [AW-1:0] a, input logic [7:0] last);
    bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
    bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(a, last);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", {7'b0, busy}, 8'h00);
    check("R1 dout", dout, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: chip erase, R6 status during erase, R10 writes while busy ignored
    cmd_erase(11'h555, 8'h10);
    bus_rd(11'h430, r);
    check("R6 erase status", r, 8'h00);
    check("R7 busy after launch", {7'b0, busy}, 8'h01);
    cmd_prog(11'h430, 8'h00);
    wait_idle();
    bus_rd(11'h000, r); check("R4 low byte", r, 8'hFF);
    bus_rd(11'h7FF, r); check("R4 top byte", r, 8'hFF);
    bus_rd(11'h430, r); check("R10 ignored program", r, 8'hFF);

    // R2: programs from the vector table
    foreach (VEC[i]) begin
      logic [34:0] v;
      v = VEC[i];
      cmd_prog(v[34:24], v[23:16]);
      bus_rd(v[34:24], r);
      check("R6 program status", r, v[7:0]);
      wait_idle();
      bus_rd(v[34:24], r);
      check("R2 programmed byte", r, v[15:8]);
    end

    // R3: sector erase of sector 1 only
    cmd_erase(11'h2C5, 8'h30);
    wait_idle();
    bus_rd(11'h200, r); check("R3 sector start", r, 8'hFF);
    bus_rd(11'h3C0, r); check("R3 sector byte", r, 8'hFF);
    bus_rd(11'h010, r); check("R3 other sector 0", r, 8'h00);
    bus_rd(11'h7FF, r); check("R3 other sector 3", r, 8'h81);

    // R8: a broken sequence resets the decoder
    bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h77);
    bus_wr(11'h555, 8'hA0); bus_wr(11'h420, 8'h00);
    repeat (4) @(negedge clk);
    check("R8 no launch", {7'b0, busy}, 8'h00);
    bus_rd(11'h420, r); check("R8 byte untouched", r, 8'hFF);

    // R5 and R9: abort a sector erase in its wait window
    cmd_erase(11'h600, 8'h30);
    repeat (600) @(negedge clk);
    force_tmo = 1'b1;
    @(negedge clk); force_tmo = 1'b0;
    repeat (300) @(negedge clk);
    check("R9 stays busy", {7'b0, busy}, 8'h01);
    bus_rd(11'h600, r); check("R9 timeout status", r, 8'h20);
    bus_wr(11'h123, 8'hF0);
    repeat (3) @(negedge clk);
    check("R9 cleared", {7'b0, busy}, 8'h00);
    bus_rd(11'h7FF, r); check("R5 preprogrammed", r, 8'h00);
    bus_rd(11'h600, r); check("R5 preprogrammed start", r, 8'h00);
    bus_rd(11'h420, r); check("R5 other sector", r, 8'hFF);

    // R11: idle output
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 11'h420;
    @(negedge clk); @(negedge clk);
    check("R11 oe high", dout, 8'h00);
    ce_n = 1'b1;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule